// File: doc/BRIEF.md
# Interrupt Source Conditioning Controller

This block sits in front of the priority logic of a small interrupt controller. It takes a bank of raw interrupt inputs and turns each one into a pending bit. Each source is conditioned on its own. Every input is synchronised and then qualified by a per-source trigger selection, either level or edge. Sources marked as external at build time also have a polarity choice, so they can trigger on high level, low level, rising edge or falling edge. Internal sources ignore the polarity bit and always treat high as active. In edge mode a latch remembers the event until something clears it.

Software controls the bank through a small register bus. It has write-1 commands that enable or disable any subset of sources, write-1 commands that force or clear the latch of edge-mode sources, and read-write registers for the trigger type, the polarity and the fast-forcing selection. Reads return the enable mask, the pending vector and the live state of the two request outputs.

Source 0 is the fast interrupt. Any enabled pending source whose fast-forcing bit is set joins it on the active-low `fiq_n` line. All other enabled pending sources drive the active-low `irq_n` line. The priority logic outside the block supplies the number of the interrupt currently being serviced, together with a vector-read strobe. On that strobe the block clears the latch of that one source, unless the source is fast-forced. A separate fast-vector-read strobe clears the latch of source 0.

Top module: `irq_src_cond`

## Requirements
- R1: After reset the mask is 0, the trigger register is 0 (all sources level-sensitive), the polarity register is all ones, no edge latch is set and both `irq_n` and `fiq_n` are 1.
- R2: Writing address 0 sets the mask bits where the write data is 1, and writing address 1 clears them. Bits written 0 are unchanged. Reading address 0 or 1 returns the mask.
- R3: In level mode (trigger bit = 0) a source is pending while its input is at the active level. The active level is high when the polarity bit (address 5) is 1 and low when it is 0. For internal sources the active level is always high. External sources are those whose bit is set in parameter `EXT_SRC` (default sources 0 and 28 to 31).
- R4: In edge mode (trigger bit at address 4 = 1) an external source sets its latch on a rising input edge when its polarity bit is 1 and on a falling edge when it is 0. An internal source uses the rising edge. The latch stays set after the input returns, and the source is pending while its latch is set.
- R5: Writing address 2 sets the latch, and writing address 3 clears it, for each bit written 1 whose source is in edge mode. Both commands have no effect on a level-mode source.
- R6: A vector-read strobe clears only the latch of the source numbered by `cur_id`. Nothing is cleared when that source's fast-forcing bit (address 6) is 1.
- R7: A fast-vector-read strobe clears the latch of source 0.
- R8: Reading address 2 or 3 returns the pending vector whatever the mask holds. Changing the mask of one source changes neither the pending bits nor the request contribution of any other source.
- R9: `fiq_n` is 0 exactly when some enabled pending source is either source 0 or fast-forced. `irq_n` is 0 exactly when some other enabled source is pending. Both outputs are registered and follow their condition one clock later.
- R10: Reading address 7 returns bit 0 = NOT `irq_n` and bit 1 = NOT `fiq_n`, with all other bits 0.
- R11: If an edge event and a clear of the same latch (software or automatic) fall in the same cycle, the latch ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_in | input | NSRC | Raw interrupt inputs, one per source |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wdata | input | NSRC | Write data, one bit per source |
| bus_rdata | output | NSRC | Read data for `bus_addr`, combinational from state |
| ivr_rd | input | 1 | Vector-read strobe |
| cur_id | input | IDW | Number of the interrupt currently being serviced |
| fvr_rd | input | 1 | Fast-vector-read strobe |
| irq_n | output | 1 | Active-low normal interrupt request |
| fiq_n | output | 1 | Active-low fast interrupt request |

## Verification
The results arrive at different times after a stimulus. An input change goes through two synchroniser stages, so a level-mode pending bit is visible two edges after the input is driven. An edge latch sets on the third edge, and the registered request lines follow one edge after the pending bit. Register writes and strobes show up in the read data after one edge and on the request lines after two. Every stimulus step in the bench therefore holds its inputs and then waits four clock edges before it samples at a falling edge, which covers the slowest of these paths. The one test that depends on the same-cycle rule (R11) counts edges exactly, so that the clear write lands on the edge where the synchronised input rises.

// File: rtl/irq_src_cond_pkg.sv
package irq_src_cond_pkg;

  typedef enum logic [2:0] {
    RS_MASK_SET = 3'd0,
    RS_MASK_CLR = 3'd1,
    RS_SW_SET   = 3'd2,
    RS_SW_CLR   = 3'd3,
    RS_TRIG     = 3'd4,
    RS_POL      = 3'd5,
    RS_FAST     = 3'd6,
    RS_STAT     = 3'd7
  } reg_sel_e;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];

endmodule

// File: rtl/irq_in_sync.sv
module irq_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_now,
  output logic [W-1:0] q_prev
);

  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign q_now  = sync_q;
  assign q_prev = prev_q;

endmodule

// File: rtl/irq_cond_bank.sv
module irq_cond_bank #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] lvl,
  input  logic [NSRC-1:0] prev,
  input  logic [NSRC-1:0] trig_edge,
  input  logic [NSRC-1:0] pol_eff,
  input  logic [NSRC-1:0] set_cmd,
  input  logic [NSRC-1:0] clr_cmd,
  output logic [NSRC-1:0] latch,
  output logic [NSRC-1:0] edge_evt,
  output logic [NSRC-1:0] pend
);

  logic [NSRC-1:0] latch_d, latch_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic act_lvl, evt_raw;
    assign act_lvl     = pol_eff[i] ? lvl[i] : ~lvl[i];
    assign evt_raw     = pol_eff[i] ? (lvl[i] & ~prev[i]) : (~lvl[i] & prev[i]);
    assign edge_evt[i] = trig_edge[i] & evt_raw;

    always_comb begin
      if (!trig_edge[i]) latch_d[i] = 1'b0;
      else               latch_d[i] = edge_evt[i] | set_cmd[i] | (latch_q[i] & ~clr_cmd[i]);
    end

    assign pend[i] = trig_edge[i] ? latch_q[i] : act_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= latch_d;
  end

  assign latch = latch_q;

endmodule

// File: rtl/irq_req_out.sv
module irq_req_out #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] mask,
  input  logic [NSRC-1:0] fast,
  output logic            irq_n,
  output logic            fiq_n
);

  localparam logic [NSRC-1:0] SRC0 = {{(NSRC-1){1'b0}}, 1'b1};

  logic [NSRC-1:0] live, fast_sel;
  logic irq_d, fiq_d, irq_q, fiq_q;

  always_comb begin
    fast_sel = fast | SRC0;
    live     = pend & mask;
    fiq_d    = ~|(live & fast_sel);
    irq_d    = ~|(live & ~fast_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b1;
      fiq_q <= 1'b1;
    end else begin
      irq_q <= irq_d;
      fiq_q <= fiq_d;
    end
  end

  assign irq_n = irq_q;
  assign fiq_n = fiq_q;

endmodule

// File: rtl/irq_src_cond.sv
module irq_src_cond
  import irq_src_cond_pkg::*;
#(
  parameter int              NSRC    = 32,
  parameter int              IDW     = $clog2(NSRC),
  parameter logic [NSRC-1:0] EXT_SRC = 32'hF000_0001
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_in,
  input  logic            bus_we,
  input  logic [2:0]      bus_addr,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] bus_rdata,
  input  logic            ivr_rd,
  input  logic [IDW-1:0]  cur_id,
  input  logic            fvr_rd,
  output logic            irq_n,
  output logic            fiq_n
);

  logic            rst_n;
  logic [NSRC-1:0] lvl, prev, latch, edge_evt, pend;
  logic [NSRC-1:0] mask_q, mask_d, trig_q, trig_d, pol_q, pol_d, fast_q, fast_d;
  logic [NSRC-1:0] pol_eff, set_cmd, clr_cmd, auto_clr;
  logic            mask_en, trig_en, pol_en, fast_en;
  reg_sel_e        sel;

  irq_rst_sync u_rst (.clk(clk), .rst_ni(rst_ni), .rst_no(rst_n));

  irq_in_sync #(.W(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(src_in), .q_now(lvl), .q_prev(prev)
  );

  assign sel = reg_sel_e'(bus_addr);

  // register file: next-state
  always_comb begin
    mask_en = bus_we && (sel == RS_MASK_SET || sel == RS_MASK_CLR);
    trig_en = bus_we && (sel == RS_TRIG);
    pol_en  = bus_we && (sel == RS_POL);
    fast_en = bus_we && (sel == RS_FAST);
    mask_d  = (sel == RS_MASK_SET) ? (mask_q | bus_wdata) : (mask_q & ~bus_wdata);
    trig_d  = bus_wdata;
    pol_d   = bus_wdata;
    fast_d  = bus_wdata;
  end

  // register file: state with explicit clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      trig_q <= '0;
      pol_q  <= '1;
      fast_q <= '0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (trig_en) trig_q <= trig_d;
      if (pol_en)  pol_q  <= pol_d;
      if (fast_en) fast_q <= fast_d;
    end
  end

  // polarity applies to external sources; internal ones are active high
  for (genvar i = 0; i < NSRC; i++) begin : g_pol
    if (EXT_SRC[i]) begin : g_ext
      assign pol_eff[i] = pol_q[i];
    end else begin : g_int
      assign pol_eff[i] = 1'b1;
    end

    if (i == 0) begin : g_fast0
      assign auto_clr[i] = fvr_rd | (ivr_rd && cur_id == IDW'(i) && !fast_q[i]);
    end else begin : g_norm
      assign auto_clr[i] = ivr_rd && cur_id == IDW'(i) && !fast_q[i];
    end
  end

  always_comb begin
    set_cmd = (bus_we && sel == RS_SW_SET) ? (bus_wdata & trig_q) : '0;
    clr_cmd = auto_clr | ((bus_we && sel == RS_SW_CLR) ? (bus_wdata & trig_q) : '0);
  end

  irq_cond_bank #(.NSRC(NSRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .prev(prev),
    .trig_edge(trig_q), .pol_eff(pol_eff),
    .set_cmd(set_cmd), .clr_cmd(clr_cmd),
    .latch(latch), .edge_evt(edge_evt), .pend(pend)
  );

  irq_req_out #(.NSRC(NSRC)) u_req (
    .clk(clk), .rst_n(rst_n), .pend(pend), .mask(mask_q), .fast(fast_q),
    .irq_n(irq_n), .fiq_n(fiq_n)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      RS_MASK_SET, RS_MASK_CLR: bus_rdata = mask_q;
      RS_SW_SET, RS_SW_CLR:     bus_rdata = pend;
      RS_TRIG:                  bus_rdata = trig_q;
      RS_POL:                   bus_rdata = pol_q;
      RS_FAST:                  bus_rdata = fast_q;
      RS_STAT:                  bus_rdata[1:0] = {~fiq_n, ~irq_n};
      default:                  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_src_cond_chk.sv
module irq_src_cond_chk
  import irq_src_cond_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int IDW  = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_we,
  input logic [2:0]      bus_addr,
  input logic [NSRC-1:0] bus_wdata,
  input logic [NSRC-1:0] mask,
  input logic [NSRC-1:0] trig,
  input logic [NSRC-1:0] fast,
  input logic [NSRC-1:0] latch,
  input logic [NSRC-1:0] edge_evt,
  input logic [NSRC-1:0] pend,
  input logic            ivr_rd,
  input logic [IDW-1:0]  cur_id,
  input logic            fvr_rd,
  input logic            irq_n,
  input logic            fiq_n
);

  localparam logic [NSRC-1:0] SRC0 = {{(NSRC-1){1'b0}}, 1'b1};

  logic wr_set, wr_mset, wr_mclr;
  assign wr_set  = bus_we && bus_addr == 3'(RS_SW_SET);
  assign wr_mset = bus_we && bus_addr == 3'(RS_MASK_SET);
  assign wr_mclr = bus_we && bus_addr == 3'(RS_MASK_CLR);

  assert_reset_state_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (irq_n && fiq_n && mask == '0));

  assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mset |=> ((mask & $past(bus_wdata)) == $past(bus_wdata)));

  assert_mask_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mclr |=> ((mask & $past(bus_wdata)) == '0));

  assert_sw_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> (($past(bus_wdata & trig) & ~latch) == '0));

  assert_vec_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ivr_rd && trig[cur_id] && !fast[cur_id] && !edge_evt[cur_id]
     && !(wr_set && bus_wdata[cur_id])) |=> !latch[$past(cur_id)]);

  assert_fvec_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fvr_rd && !edge_evt[0] && !(wr_set && bus_wdata[0])) |=> !latch[0]);

  assert_irq_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_n == !$past(|(pend & mask & ~(fast | SRC0)))));

  assert_fiq_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fiq_n == !$past(|(pend & mask & (fast | SRC0)))));

  assert_edge_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(edge_evt) & ~latch) == '0));

endmodule

bind irq_src_cond irq_src_cond_chk #(.NSRC(NSRC), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .mask(mask_q), .trig(trig_q), .fast(fast_q),
  .latch(latch), .edge_evt(edge_evt), .pend(pend), .ivr_rd(ivr_rd),
  .cur_id(cur_id), .fvr_rd(fvr_rd), .irq_n(irq_n), .fiq_n(fiq_n)
);

// File: tb/sim_irq_src_cond.sv
module sim_irq_src_cond;

  localparam int  CLK_PERIOD = 10;
  localparam int  WATCHDOG   = 20000;
  localparam int  NV         = 14;

  typedef struct packed {
    logic [31:0] src;
    logic        we;
    logic [2:0]  wa;
    logic [31:0] wd;
    logic [2:0]  ra;
    logic [31:0] exp;
    logic        eirq;
    logic        efiq;
    logic [3:0]  req;
  } vec_t;

  // addresses: 0 mask set, 1 mask clr, 2 sw set/pend, 3 sw clr/pend,
  // 4 trigger, 5 polarity, 6 fast, 7 status
  localparam vec_t TBL [NV] = '{
    '{32'h0000_0000, 1'b1, 3'd0, 32'h0000_0006, 3'd0, 32'h0000_0006, 1'b1, 1'b1, 4'd2},  // R2 set
    '{32'h0000_0000, 1'b1, 3'd1, 32'h0000_0004, 3'd0, 32'h0000_0002, 1'b1, 1'b1, 4'd2},  // R2 clr
    '{32'h0000_0002, 1'b0, 3'd0, 32'h0000_0000, 3'd2, 32'h0000_0002, 1'b0, 1'b1, 4'd3},  // R3 level
    '{32'h0000_0004, 1'b0, 3'd0, 32'h0000_0000, 3'd2, 32'h0000_0004, 1'b1, 1'b1, 4'd8},  // R8 masked pend
    '{32'h0000_0000, 1'b1, 3'd5, 32'h7FFF_FFFF, 3'd2, 32'h8000_0000, 1'b1, 1'b1, 4'd3},  // R3 low level
    '{32'h0000_0000, 1'b1, 3'd0, 32'h8000_0000, 3'd7, 32'h0000_0001, 1'b0, 1'b1, 4'd10}, // R10 status
    '{32'h8000_0000, 1'b1, 3'd5, 32'hFFFF_FFFF, 3'd2, 32'h8000_0000, 1'b0, 1'b1, 4'd3},  // R3 high level
    '{32'h0000_0000, 1'b1, 3'd4, 32'h0000_0003, 3'd2, 32'h0000_0000, 1'b1, 1'b1, 4'd4},  // R4 edge mode
    '{32'h0000_0002, 1'b0, 3'd0, 32'h0000_0000, 3'd2, 32'h0000_0002, 1'b0, 1'b1, 4'd4},  // R4 rising
    '{32'h0000_0000, 1'b0, 3'd0, 32'h0000_0000, 3'd2, 32'h0000_0002, 1'b0, 1'b1, 4'd4},  // R4 held
    '{32'h0000_0000, 1'b1, 3'd3, 32'h0000_0002, 3'd2, 32'h0000_0000, 1'b1, 1'b1, 4'd5},  // R5 sw clr
    '{32'h0000_0000, 1'b1, 3'd2, 32'h0000_0004, 3'd2, 32'h0000_0000, 1'b1, 1'b1, 4'd5},  // R5 level no effect
    '{32'h0000_0000, 1'b1, 3'd2, 32'h0000_0001, 3'd2, 32'h0000_0001, 1'b1, 1'b1, 4'd5},  // R5 sw set
    '{32'h0000_0000, 1'b1, 3'd0, 32'h0000_0001, 3'd7, 32'h0000_0002, 1'b1, 1'b0, 4'd9}   // R9 fiq
  };

  logic        clk, rst_ni, bus_we, ivr_rd, fvr_rd, irq_n, fiq_n;
  logic [31:0] src_in, bus_wdata, bus_rdata;
  logic [2:0]  bus_addr;
  logic [4:0]  cur_id;
  int          errors, checks;

  irq_src_cond u0 (
    .clk(clk), .rst_ni(rst_ni), .src_in(src_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ivr_rd(ivr_rd), .cur_id(cur_id), .fvr_rd(fvr_rd),
    .irq_n(irq_n), .fiq_n(fiq_n)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run hung (actual timeout, expected completion)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic wait_edges(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // drive inputs and an optional one-cycle write, then let every path settle
  task automatic step(input logic [31:0] s, input logic we, input logic [2:0] a,
                      input logic [31:0] d);
    @(negedge clk);
    src_in    = s;
    bus_we    = we;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    wait_edges(3);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    step(src_in, 1'b1, a, d);
  endtask

  task automatic strobe(input logic fast, input logic [4:0] id);
    @(negedge clk);
    ivr_rd = ~fast;
    fvr_rd = fast;
    cur_id = id;
    @(negedge clk);
    ivr_rd = 1'b0;
    fvr_rd = 1'b0;
    wait_edges(3);
  endtask

  task automatic check(input logic [2:0] ra, input logic [31:0] exp,
                       input logic eirq, input logic efiq, input string req);
    bus_addr = ra;
    #1;
    checks++;
    if (bus_rdata !== exp || irq_n !== eirq || fiq_n !== efiq) begin
      errors++;
      $display("FAIL %s: addr %0d data=%h irq_n=%b fiq_n=%b, expected data=%h irq_n=%b fiq_n=%b",
               req, ra, bus_rdata, irq_n, fiq_n, exp, eirq, efiq);
    end
  endtask

  initial begin
    errors = 0; checks = 0;
    rst_ni = 1'b0; src_in = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    ivr_rd = 1'b0; fvr_rd = 1'b0; cur_id = '0;
    wait_edges(3);
    rst_ni = 1'b1;
    wait_edges(4);

    // R1 reset state
    check(3'd0, 32'h0000_0000, 1'b1, 1'b1, "R1 mask");
    check(3'd4, 32'h0000_0000, 1'b1, 1'b1, "R1 trigger");
    check(3'd5, 32'hFFFF_FFFF, 1'b1, 1'b1, "R1 polarity");
    check(3'd2, 32'h0000_0000, 1'b1, 1'b1, "R1 pending");

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].src, TBL[i].we, TBL[i].wa, TBL[i].wd);
      check(TBL[i].ra, TBL[i].exp, TBL[i].eirq, TBL[i].efiq,
            $sformatf("R%0d step %0d", TBL[i].req, i));
    end

    // R7 fast vector read clears source 0
    strobe(1'b1, 5'd0);
    check(3'd2, 32'h0000_0000, 1'b1, 1'b1, "R7");

    // R6 vector read clears only the current source
    wr(3'd2, 32'h0000_0003);
    strobe(1'b0, 5'd1);
    check(3'd2, 32'h0000_0001, 1'b1, 1'b0, "R6 only current");

    // R6 fast-forced source keeps its latch; R9 it moves to fiq_n
    wr(3'd6, 32'h0000_0002);
    wr(3'd2, 32'h0000_0002);
    strobe(1'b0, 5'd1);
    check(3'd2, 32'h0000_0003, 1'b1, 1'b0, "R6 fast inhibit / R9");

    // R11 edge event in the same cycle as a software clear
    wr(3'd6, 32'h0000_0000);
    wr(3'd3, 32'h0000_0003);
    check(3'd2, 32'h0000_0000, 1'b1, 1'b1, "R5 cleared");
    @(negedge clk);
    src_in = 32'h0000_0002;
    wait_edges(2);
    bus_we = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h0000_0002;
    @(negedge clk);
    bus_we = 1'b0;
    wait_edges(3);
    check(3'd2, 32'h0000_0002, 1'b0, 1'b1, "R11");
    step(32'h0000_0000, 1'b1, 3'd3, 32'h0000_0002);
    check(3'd2, 32'h0000_0000, 1'b1, 1'b1, "R11 cleanup");

    // R3 polarity ignored on internal, low level on external
    step(32'h0000_0020, 1'b1, 3'd5, 32'h0000_0000);
    check(3'd2, 32'hF000_0020, 1'b0, 1'b1, "R3 polarity");

    // R4 falling-edge external source 0
    step(32'h0000_0021, 1'b0, 3'd0, 32'h0);
    check(3'd2, 32'hF000_0020, 1'b0, 1'b1, "R4 no rise trigger");
    step(32'h0000_0020, 1'b0, 3'd0, 32'h0);
    check(3'd2, 32'hF000_0021, 1'b0, 1'b0, "R4 falling");

    // R8 disabling one source leaves others alone
    wr(3'd1, 32'h8000_0000);
    check(3'd2, 32'hF000_0021, 1'b1, 1'b0, "R8 disable");
    check(3'd7, 32'h0000_0002, 1'b1, 1'b0, "R10 status");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule